// File: doc/BRIEF.md
# Receive Carrier Loss Monitor

This block watches the recovered receive bit stream of a line interface and decides whether a carrier is present. A bit is taken whenever the bit-enable input is high. A long unbroken run of zeros declares loss of carrier. The required run length is chosen by a select input: a short run or a long run.

Once loss is declared, the same condition does not clear it. Instead, the incoming bits are grouped into fixed blocks of 112, counted from the first bit after the declaring one. Loss is released at the end of any block that holds enough ones. The monitor also pulses a flag whenever a run of zeros reaches sixteen.

It produces four outputs:
- the live loss status;
- a one-cycle change pulse, meant for an interrupt or transition register;
- a clock-source select that steers the downstream recovered clock to the master reference while loss is active;
- the sixteen-zero flag.

Top module: `rcl_monitor`

## Requirements
- R1: With `thr_sel` = 0, `loss_o` goes to 1 in the cycle after the 192nd consecutive accepted zero. It stays 0 after the 191st.
- R2: With `thr_sel` = 1, `loss_o` goes to 1 in the cycle after the 2048th consecutive accepted zero. It stays 0 after the 2047th.
- R3: An accepted one restarts the zero run. A later declaration needs a full threshold of zeros counted from that one.
- R4: During loss, accepted bits form blocks of 112, starting with the first bit after the declaring zero. `loss_o` returns to 0 in the cycle after the last bit of a block that holds at least 14 ones, with that last bit included in the count. A block with 13 or fewer ones leaves loss set.
- R5: `zero16_o` is high for exactly one cycle, the cycle after the 16th consecutive accepted zero. It stays low after the 15th and after the 17th.
- R6: `loss_chg_o` is high for exactly one cycle, in the first cycle in which `loss_o` shows a new value, for both rising and falling changes.
- R7: `clk_sel_o` is 1 (master reference) while `loss_o` is 1, and 0 (recovered line clock) while `loss_o` is 0.
- R8: In cycles where `bit_en` is 0, `rx_bit` has no effect. Zeros there do not extend the run, and ones there do not restart it.
- R9: An active-low `rst_n` forces `loss_o`, `loss_chg_o`, `zero16_o` and `clk_sel_o` to 0 and clears the zero run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Marks a cycle that carries one received bit |
| rx_bit | input | 1 | Received bit, 1 = mark (pulse), 0 = space |
| thr_sel | input | 1 | Declare threshold: 0 = short run, 1 = long run |
| loss_o | output | 1 | Carrier loss status |
| loss_chg_o | output | 1 | One-cycle pulse when the loss status changes |
| zero16_o | output | 1 | One-cycle pulse on a sixteen-zero run |
| clk_sel_o | output | 1 | Clock source: 1 = master reference, 0 = line clock |

## Verification
Every result is registered once, so each one is due in the cycle right after the clock edge that accepted the deciding bit:
- the declaration;
- the release at the end of a block;
- the sixteen-zero pulse;
- the change pulse.

The bench drives each bit for exactly one edge and reads the outputs 1 ns after that edge. It then samples again one idle cycle later to confirm that the pulses have dropped. Near-miss counts (191, 2047, 15 zeros, 13 ones, 111 block bits) are checked at the same sampling point, so an off-by-one in any counter shows up as a wrong value in a named cycle.

// File: rtl/rcl_pkg.sv
`timescale 1ns/1ps
package rcl_pkg;
   typedef enum logic {
      ST_LIVE = 1'b0,
      ST_LOST = 1'b1
   } rcl_state_e;

   typedef enum logic {
      CS_LINE = 1'b0,
      CS_REF  = 1'b1
   } clk_src_e;
endpackage

// File: rtl/rcl_zero_run.sv
`timescale 1ns/1ps
// Counts consecutive accepted zeros, saturating at the selected limit.
module rcl_zero_run #(
   parameter int unsigned SHORT_RUN = 192,
   parameter int unsigned LONG_RUN  = 2048,
   parameter int unsigned FLAG_RUN  = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic rx_bit,
   input  logic thr_sel,
   output logic run_hit,
   output logic flag_hit
);
   localparam int unsigned CW = $clog2(LONG_RUN + 1);

   if (SHORT_RUN >= LONG_RUN) begin : g_bad_order
      $error("rcl_zero_run: SHORT_RUN must be below LONG_RUN");
   end
   if (FLAG_RUN == 0 || FLAG_RUN >= SHORT_RUN) begin : g_bad_flag
      $error("rcl_zero_run: FLAG_RUN must lie in 1..SHORT_RUN-1");
   end

   logic [CW-1:0] run_q;
   logic [CW-1:0] limit;
   logic [CW:0]   run_inc;
   logic          zero_in;

   assign limit    = thr_sel ? CW'(LONG_RUN) : CW'(SHORT_RUN);
   assign run_inc  = {1'b0, run_q} + (CW+1)'(1);
   assign zero_in  = bit_en & ~rx_bit;
   assign run_hit  = zero_in && (run_inc >= {1'b0, limit});
   assign flag_hit = zero_in && (run_q == CW'(FLAG_RUN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (bit_en) begin
         if (rx_bit) begin
            run_q <= '0;
         end else if (run_q < limit) begin
            run_q <= run_inc[CW-1:0];
         end
      end
   end
endmodule

// File: rtl/rcl_density_win.sv
`timescale 1ns/1ps
// Ones-density check over consecutive fixed blocks while loss is active.
module rcl_density_win #(
   parameter int unsigned WIN_LEN  = 112,
   parameter int unsigned WIN_ONES = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic bit_en,
   input  logic rx_bit,
   output logic restore
);
   localparam int unsigned PW = $clog2(WIN_LEN);
   localparam int unsigned OW = $clog2(WIN_ONES + 1);

   if (WIN_LEN < 2) begin : g_bad_len
      $error("rcl_density_win: WIN_LEN must be at least 2");
   end
   if (WIN_ONES == 0 || WIN_ONES > WIN_LEN) begin : g_bad_ones
      $error("rcl_density_win: WIN_ONES must lie in 1..WIN_LEN");
   end

   logic [PW-1:0] pos_q;
   logic [OW-1:0] ones_q;
   logic          last_bit;
   logic          enough;

   assign last_bit = (pos_q == PW'(WIN_LEN - 1));
   assign enough   = rx_bit ? (ones_q >= OW'(WIN_ONES - 1))
                            : (ones_q >= OW'(WIN_ONES));
   assign restore  = active && bit_en && last_bit && enough;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q  <= '0;
         ones_q <= '0;
      end else if (!active) begin
         pos_q  <= '0;
         ones_q <= '0;
      end else if (bit_en) begin
         if (last_bit) begin
            pos_q  <= '0;
            ones_q <= '0;
         end else begin
            pos_q <= pos_q + PW'(1);
            if (rx_bit && ones_q != OW'(WIN_ONES)) begin
               ones_q <= ones_q + OW'(1);
            end
         end
      end
   end
endmodule

// File: rtl/rcl_state.sv
`timescale 1ns/1ps
// Loss state register, change pulse and registered run flag.
module rcl_state
   import rcl_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic declare,
   input  logic restore,
   input  logic flag_in,
   output logic lost,
   output logic chg,
   output logic flag_out
);
   rcl_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_LIVE: if (declare) state_d = ST_LOST;
         ST_LOST: if (restore) state_d = ST_LIVE;
         default: state_d = ST_LIVE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_LIVE;
         chg      <= 1'b0;
         flag_out <= 1'b0;
      end else begin
         state_q  <= state_d;
         chg      <= (state_d != state_q);
         flag_out <= flag_in;
      end
   end

   assign lost = (state_q == ST_LOST);
endmodule

// File: rtl/rcl_monitor.sv
`timescale 1ns/1ps
module rcl_monitor
   import rcl_pkg::*;
#(
   parameter int unsigned SHORT_RUN = 192,
   parameter int unsigned LONG_RUN  = 2048,
   parameter int unsigned FLAG_RUN  = 16,
   parameter int unsigned WIN_LEN   = 112,
   parameter int unsigned WIN_ONES  = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic rx_bit,
   input  logic thr_sel,
   output logic loss_o,
   output logic loss_chg_o,
   output logic zero16_o,
   output logic clk_sel_o
);
   logic run_hit;
   logic flag_hit;
   logic restore;
   logic lost;

   rcl_zero_run #(
      .SHORT_RUN (SHORT_RUN),
      .LONG_RUN  (LONG_RUN),
      .FLAG_RUN  (FLAG_RUN)
   ) u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .rx_bit   (rx_bit),
      .thr_sel  (thr_sel),
      .run_hit  (run_hit),
      .flag_hit (flag_hit)
   );

   rcl_density_win #(
      .WIN_LEN  (WIN_LEN),
      .WIN_ONES (WIN_ONES)
   ) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (lost),
      .bit_en  (bit_en),
      .rx_bit  (rx_bit),
      .restore (restore)
   );

   rcl_state u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .declare  (run_hit),
      .restore  (restore),
      .flag_in  (flag_hit),
      .lost     (lost),
      .chg      (loss_chg_o),
      .flag_out (zero16_o)
   );

   assign loss_o    = lost;
   assign clk_sel_o = lost ? CS_REF : CS_LINE;
endmodule

// File: rtl/rcl_monitor_chk.sv
`timescale 1ns/1ps
module rcl_monitor_chk #(
   parameter int unsigned WIN_LEN = 112
) (
   input logic clk,
   input logic rst_n,
   input logic bit_en,
   input logic rx_bit,
   input logic loss_o,
   input logic loss_chg_o,
   input logic zero16_o,
   input logic clk_sel_o
);
   localparam int unsigned PW = $clog2(WIN_LEN);

   logic [PW-1:0] blk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_q <= '0;
      end else if (!loss_o) begin
         blk_q <= '0;
      end else if (bit_en) begin
         blk_q <= (blk_q == PW'(WIN_LEN - 1)) ? '0 : blk_q + PW'(1);
      end
   end

   // R1 R2
   decl_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(loss_o) |-> $past(bit_en && !rx_bit));

   // R4
   clear_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(loss_o) |-> ($past(bit_en) && blk_q == '0));

   // R6
   chg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loss_chg_o |-> (loss_o != $past(loss_o)));

   // R6
   chg_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loss_o != $past(loss_o)) |-> loss_chg_o);

   // R5
   flag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zero16_o |-> $past(bit_en && !rx_bit));

   // R5
   flag_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zero16_o |=> !zero16_o);

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> ($stable(clk_sel_o) && !zero16_o));
endmodule

bind rcl_monitor rcl_monitor_chk #(.WIN_LEN(WIN_LEN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bit_en     (bit_en),
   .rx_bit     (rx_bit),
   .loss_o     (loss_o),
   .loss_chg_o (loss_chg_o),
   .zero16_o   (zero16_o),
   .clk_sel_o  (clk_sel_o)
);

// File: tb/test_rcl_monitor.sv
`timescale 1ns/1ps
module test_rcl_monitor;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 1'b0;
   logic rx_bit = 1'b0;
   logic thr_sel = 1'b0;
   logic loss_o, loss_chg_o, zero16_o, clk_sel_o;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   rcl_monitor i_rcl_monitor (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_en     (bit_en),
      .rx_bit     (rx_bit),
      .thr_sel    (thr_sel),
      .loss_o     (loss_o),
      .loss_chg_o (loss_chg_o),
      .zero16_o   (zero16_o),
      .clk_sel_o  (clk_sel_o)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk);
      bit_en = 1'b1;
      rx_bit = b;
      @(posedge clk);
      #1;
      bit_en = 1'b0;
      rx_bit = 1'b0;
   endtask

   task automatic send_run(input logic b, input int n);
      for (int i = 0; i < n; i++) send_bit(b);
   endtask

   task automatic idle(input int n, input logic level);
      @(negedge clk);
      rx_bit = level;
      repeat (n) @(posedge clk);
      #1;
      rx_bit = 1'b0;
   endtask

   task automatic do_reset(input logic sel);
      @(negedge clk);
      rst_n   = 1'b0;
      bit_en  = 1'b0;
      rx_bit  = 1'b0;
      thr_sel = sel;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic test_reset_state();
      do_reset(1'b0);
      chk("R9 loss after reset", loss_o, 1'b0);
      chk("R9 change pulse after reset", loss_chg_o, 1'b0);
      chk("R9 flag after reset", zero16_o, 1'b0);
      chk("R9 clock select after reset", clk_sel_o, 1'b0);
   endtask

   task automatic test_short_threshold();
      do_reset(1'b0);
      send_run(1'b0, 191);
      chk("R1 no loss after 191 zeros", loss_o, 1'b0);
      send_bit(1'b0);
      chk("R1 loss after 192 zeros", loss_o, 1'b1);
      chk("R6 change pulse on declare", loss_chg_o, 1'b1);
      chk("R7 reference clock during loss", clk_sel_o, 1'b1);
      idle(1, 1'b0);
      chk("R6 change pulse ends", loss_chg_o, 1'b0);
      chk("R1 loss holds", loss_o, 1'b1);
   endtask

   task automatic test_long_threshold();
      do_reset(1'b1);
      send_run(1'b0, 2047);
      chk("R2 no loss after 2047 zeros", loss_o, 1'b0);
      send_bit(1'b0);
      chk("R2 loss after 2048 zeros", loss_o, 1'b1);
   endtask

   task automatic test_one_restarts();
      do_reset(1'b0);
      send_run(1'b0, 191);
      send_bit(1'b1);
      send_run(1'b0, 191);
      chk("R3 run restarted by one", loss_o, 1'b0);
      send_bit(1'b0);
      chk("R3 loss after full run following one", loss_o, 1'b1);
   endtask

   task automatic test_flag16();
      do_reset(1'b0);
      send_run(1'b0, 15);
      chk("R5 no flag after 15 zeros", zero16_o, 1'b0);
      send_bit(1'b0);
      chk("R5 flag after 16 zeros", zero16_o, 1'b1);
      idle(1, 1'b0);
      chk("R5 flag lasts one cycle", zero16_o, 1'b0);
      send_bit(1'b0);
      chk("R5 no flag at 17th zero", zero16_o, 1'b0);
   endtask

   task automatic test_clear_window();
      do_reset(1'b0);
      send_run(1'b0, 192);
      chk("R4 loss declared before window", loss_o, 1'b1);
      send_run(1'b1, 13);
      send_run(1'b0, 99);
      chk("R4 block with 13 ones keeps loss", loss_o, 1'b1);
      send_run(1'b1, 13);
      send_run(1'b0, 98);
      chk("R4 loss holds before block end", loss_o, 1'b1);
      send_bit(1'b1);
      chk("R4 cleared by 14th one on last bit", loss_o, 1'b0);
      chk("R6 change pulse on clear", loss_chg_o, 1'b1);
      chk("R7 line clock after clear", clk_sel_o, 1'b0);
   endtask

   task automatic test_idle_ignored();
      do_reset(1'b0);
      send_run(1'b0, 190);
      idle(20, 1'b0);
      chk("R8 idle zeros not counted", loss_o, 1'b0);
      idle(20, 1'b1);
      send_bit(1'b0);
      chk("R8 idle ones did not restart run (191)", loss_o, 1'b0);
      send_bit(1'b0);
      chk("R8 loss at 192 accepted zeros", loss_o, 1'b1);
   endtask

   task automatic test_reset_mid_loss();
      do_reset(1'b0);
      send_run(1'b0, 192);
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      chk("R9 reset clears loss", loss_o, 1'b0);
      chk("R9 reset clears clock select", clk_sel_o, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      send_run(1'b0, 191);
      chk("R9 run cleared by reset", loss_o, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      test_reset_state();
      test_short_threshold();
      test_long_threshold();
      test_one_restarts();
      test_flag16();
      test_clear_window();
      test_idle_ignored();
      test_reset_mid_loss();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule